// File: doc/BRIEF.md
# Neuron Multiply-Accumulate Step with Sigmoid Activation

This block evaluates one step of an artificial neuron in signed Q16.16 fixed point. A weight line and an input line, each holding seven 32-bit operands in a 256-bit word, are written into a two-slot register array. A start pulse takes a snapshot of both lines and forms all seven lane products in parallel. A three-level registered adder tree reduces the products to one sum.

The sum either starts a new accumulation or is added to the running total left by the previous step. The second case lets a neuron with more than seven inputs be fed over several steps. The saturated total is clamped to [-8, +8) and mapped through a 256-entry sigmoid table that is built at elaboration time. There is no interpolation between entries, so the activation is a staircase function of the total.

Results appear on a result port with a one-cycle valid pulse at a fixed latency. A new step may start on every cycle.

Top module: `neuron_mac_step`

## Requirements
- R1: With `ld_en` high, `ld_sel`=0 writes `ld_line` into the weight slot and `ld_sel`=1 writes it into the input slot. Lane i occupies bits [32i+31:32i] for i = 0..6, and bits [255:224] have no effect on any result.
- R2: Each lane product is the full signed product of two Q16.16 operands, shifted right arithmetically by 16 (rounding toward minus infinity) and saturated to the signed 32-bit range.
- R3: The step total is the sum of the seven lane products when `first` is 1 at start. When `first` is 0 it is that sum plus the previous step's accumulated total. `res_sum` shows the total.
- R4: The accumulated total saturates to 0x7FFFFFFF or 0x80000000 instead of wrapping, and a saturated total stays in force for later steps.
- R5: `res_valid` is high for exactly one cycle, six clock edges after the edge that samples `start`. Starts on consecutive cycles give results on consecutive cycles, in order.
- R6: The table index is 0 for totals below -8.0 (-0x80000) and 255 for totals of 8.0 (0x80000) or more. Between those limits it is (total + 0x80000) >> 12.
- R7: Table entry k equals round(65535 / (1 + e^(-x))), with x = (2k - 255)/32, within one LSB. A non-negative total gives `res_act` >= 0x8000, and a negative total gives `res_act` < 0x8000.
- R8: A step uses the register contents present at its start edge. Loads made after that edge do not change its result.
- R9: `res_sum` and `res_act` hold their values in every cycle where `res_valid` is low.
- R10: Reset clears the outputs, both operand slots and the accumulated total to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write one operand slot this cycle |
| ld_sel | input | 1 | Slot to write: 0 weights, 1 inputs |
| ld_line | input | 256 | Seven packed Q16.16 operands; top word ignored |
| start | input | 1 | Begin a step from the current slot contents |
| first | input | 1 | With start: discard the previous accumulated total |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_sum | output | 32 | Saturated accumulated total, Q16.16 |
| res_act | output | 16 | Sigmoid level, unsigned fraction of 65535 |

## Verification
The bench builds the block with its default seven lanes and a 256-bit line. At that size the spare top word carries random junk on every load, and the padded eighth tree leaf is always present. The lane operands are small enough that directed values can land a total exactly on each clamp edge of the table (-8.0, just below it, just under +8.0, +8.0, zero and minus one LSB). Full-scale operands push both the per-lane product and the accumulated total into saturation from either side. Random steps mix fresh and chained accumulation with loads that overwrite a slot one cycle after start, and one burst of back-to-back starts exercises the feedback across pipelined steps.

// File: rtl/nmac_pkg.sv
package nmac_pkg;
  localparam int unsigned OPW        = 32;  // operand width, Q16.16
  localparam int unsigned FRAC       = 16;  // fraction bits
  localparam int unsigned ACT_W      = 16;  // activation width
  localparam int unsigned IDX_W      = 8;   // table index width
  localparam int unsigned LUT_N      = 1 << IDX_W;
  localparam int unsigned RANGE_LOG2 = 3;   // clamp to +/- 2^3
  localparam int unsigned IDX_SHIFT  = FRAC + RANGE_LOG2 + 1 - IDX_W;

  localparam logic signed [OPW-1:0] Q_MAX = {1'b0, {(OPW-1){1'b1}}};
  localparam logic signed [OPW-1:0] Q_MIN = {1'b1, {(OPW-1){1'b0}}};
  localparam logic signed [OPW-1:0] CLAMP = OPW'(1 << (FRAC + RANGE_LOG2));
  localparam logic signed [63:0] W_MAX = 64'sh0000_0000_7FFF_FFFF;
  localparam logic signed [63:0] W_MIN = 64'shFFFF_FFFF_8000_0000;

  // e^(-1/32) and e^(-1/16) in Q0.32: half a bin and one bin for 256 bins over 16.0
  localparam logic [63:0] U_FIRST = 64'd4162825044;
  localparam logic [63:0] E_STEP  = 64'd4034748382;

  function automatic logic signed [OPW-1:0] q_sat(input logic signed [63:0] v);
    if (v > W_MAX)      return Q_MAX;
    else if (v < W_MIN) return Q_MIN;
    else                return v[OPW-1:0];
  endfunction

  function automatic logic signed [OPW-1:0] q_mul(input logic signed [OPW-1:0] a,
                                                  input logic signed [OPW-1:0] b);
    logic signed [63:0] ae, be, full;
    ae   = 64'(a);
    be   = 64'(b);
    full = ae * be;
    return q_sat(full >>> FRAC);
  endfunction

  function automatic logic [IDX_W-1:0] lut_index(input logic signed [OPW-1:0] s);
    logic signed [OPW-1:0] off;
    if (s < -CLAMP)  return '0;
    if (s >= CLAMP)  return '1;
    off = s + CLAMP;
    return IDX_W'(off >>> IDX_SHIFT);
  endfunction

  // Bin k centre x = (2k - 255)/32; mirrored pairs share u = e^(-|x|).
  function automatic logic [LUT_N*ACT_W-1:0] build_lut();
    logic [LUT_N*ACT_W-1:0] t;
    logic [63:0] u, den, pos, neg;
    t = '0;
    u = U_FIRST;
    for (int j = 0; j < LUT_N/2; j++) begin
      den = 64'h1_0000_0000 + u;
      pos = ((64'd65535 << 32) + (den >> 1)) / den;
      neg = (64'd65535 * u + (den >> 1)) / den;
      t[(LUT_N/2 + j)*ACT_W +: ACT_W]     = ACT_W'(pos);
      t[(LUT_N/2 - 1 - j)*ACT_W +: ACT_W] = ACT_W'(neg);
      u = (u * E_STEP) >> 32;
    end
    return t;
  endfunction
endpackage

// File: rtl/nmac_lanes.sv
module nmac_lanes import nmac_pkg::*; #(
  parameter int unsigned N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             first,
  input  logic [N*OPW-1:0] wgt,
  input  logic [N*OPW-1:0] inp,
  output logic [N*OPW-1:0] prod,
  output logic             vld,
  output logic             fst
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod <= '0;
      vld  <= 1'b0;
      fst  <= 1'b0;
    end else begin
      vld <= start;
      fst <= first;
      if (start) begin
        for (int i = 0; i < int'(N); i++)
          prod[i*OPW +: OPW] <= q_mul($signed(wgt[i*OPW +: OPW]), $signed(inp[i*OPW +: OPW]));
      end
    end
  end
endmodule

// File: rtl/nmac_tree.sv
module nmac_tree import nmac_pkg::*; #(
  parameter int unsigned N  = 7,
  parameter int unsigned TW = 36
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic                 in_first,
  input  logic [N*OPW-1:0]     leaves,
  output logic signed [TW-1:0] sum,
  output logic                 out_vld,
  output logic                 out_first
);
  localparam int unsigned LV = $clog2(N);
  localparam int unsigned NP = 1 << LV;

  logic signed [TW-1:0] leaf [NP];
  for (genvar i = 0; i < int'(NP); i++) begin : g_leaf
    if (i < int'(N)) begin : g_use
      assign leaf[i] = TW'($signed(leaves[i*OPW +: OPW]));
    end else begin : g_pad
      assign leaf[i] = '0;
    end
  end

  for (genvar l = 0; l < int'(LV); l++) begin : g_lv
    localparam int unsigned W = NP >> (l + 1);
    logic signed [TW-1:0] src [2*W];
    logic signed [TW-1:0] s [W];
    logic pv, pf, v, f;
    if (l == 0) begin : g_from_leaf
      assign src = leaf;
      assign pv  = in_vld;
      assign pf  = in_first;
    end else begin : g_from_lvl
      assign src = g_lv[l-1].s;
      assign pv  = g_lv[l-1].v;
      assign pf  = g_lv[l-1].f;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < int'(W); i++) s[i] <= '0;
        v <= 1'b0;
        f <= 1'b0;
      end else begin
        for (int i = 0; i < int'(W); i++) s[i] <= src[2*i] + src[2*i+1];
        v <= pv;
        f <= pf;
      end
    end
  end

  assign sum       = g_lv[LV-1].s[0];
  assign out_vld   = g_lv[LV-1].v;
  assign out_first = g_lv[LV-1].f;
endmodule

// File: rtl/nmac_act.sv
module nmac_act import nmac_pkg::*; #(
  parameter int unsigned TW = 36
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_vld,
  input  logic                  in_first,
  input  logic signed [TW-1:0]  in_sum,
  output logic                  out_vld,
  output logic signed [OPW-1:0] out_sum,
  output logic [ACT_W-1:0]      out_act,
  output logic                  ev_sat_hi,
  output logic                  ev_sat_lo
);
  localparam logic [LUT_N*ACT_W-1:0] LUT = build_lut();

  logic signed [OPW-1:0] acc_q, acc_next;
  logic                  acc_vld_q;
  logic signed [TW:0]    total;

  always_comb begin
    total = in_first ? (TW+1)'(in_sum) : (TW+1)'(in_sum) + (TW+1)'(acc_q);
  end

  assign ev_sat_hi = in_vld && (total > (TW+1)'(Q_MAX));
  assign ev_sat_lo = in_vld && (total < (TW+1)'(Q_MIN));

  always_comb begin
    if (ev_sat_hi)      acc_next = Q_MAX;
    else if (ev_sat_lo) acc_next = Q_MIN;
    else                acc_next = total[OPW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      acc_vld_q <= 1'b0;
      out_vld   <= 1'b0;
      out_sum   <= '0;
      out_act   <= '0;
    end else begin
      acc_vld_q <= in_vld;
      out_vld   <= acc_vld_q;
      if (in_vld) acc_q <= acc_next;
      if (acc_vld_q) begin
        out_sum <= acc_q;
        out_act <= LUT[lut_index(acc_q)*ACT_W +: ACT_W];
      end
    end
  end
endmodule

// File: rtl/neuron_mac_step.sv
module neuron_mac_step import nmac_pkg::*; #(
  parameter int unsigned LANES  = 7,
  parameter int unsigned LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic              ld_sel,
  input  logic [LINE_W-1:0] ld_line,
  input  logic              start,
  input  logic              first,
  output logic              res_valid,
  output logic [OPW-1:0]    res_sum,
  output logic [ACT_W-1:0]  res_act
);
  localparam int unsigned USED_W = LANES * OPW;
  localparam int unsigned TREE_W = OPW + $clog2(LANES) + 1;

  logic [USED_W-1:0] wgt_q, inp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wgt_q <= '0;
      inp_q <= '0;
    end else if (ld_en) begin
      if (ld_sel) inp_q <= ld_line[USED_W-1:0];
      else        wgt_q <= ld_line[USED_W-1:0];
    end
  end

  if (LINE_W > USED_W) begin : g_spare
    logic unused_spare;
    assign unused_spare = ^ld_line[LINE_W-1:USED_W];
  end

  logic [USED_W-1:0]        lane_prod;
  logic                     lane_vld, lane_first;
  logic signed [TREE_W-1:0] tree_sum;
  logic                     tree_vld, tree_first;
  logic signed [OPW-1:0]    act_sum;
  logic                     ev_sat_hi, ev_sat_lo;

  nmac_lanes #(.N(LANES)) u_lanes (
    .clk(clk), .rst_n(rst_n), .start(start), .first(first),
    .wgt(wgt_q), .inp(inp_q),
    .prod(lane_prod), .vld(lane_vld), .fst(lane_first)
  );

  nmac_tree #(.N(LANES), .TW(TREE_W)) u_tree (
    .clk(clk), .rst_n(rst_n), .in_vld(lane_vld), .in_first(lane_first),
    .leaves(lane_prod), .sum(tree_sum), .out_vld(tree_vld), .out_first(tree_first)
  );

  nmac_act #(.TW(TREE_W)) u_act (
    .clk(clk), .rst_n(rst_n), .in_vld(tree_vld), .in_first(tree_first),
    .in_sum(tree_sum), .out_vld(res_valid), .out_sum(act_sum), .out_act(res_act),
    .ev_sat_hi(ev_sat_hi), .ev_sat_lo(ev_sat_lo)
  );

  assign res_sum = act_sum;
endmodule

// File: rtl/nmac_chk.sv
module nmac_chk import nmac_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             res_valid,
  input logic             ev_sat_hi,
  input logic             ev_sat_lo,
  input logic [OPW-1:0]   res_sum,
  input logic [ACT_W-1:0] res_act
);
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##6 res_valid);

  p_sat_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sat_hi |-> ##2 (res_sum == Q_MAX));

  p_sat_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sat_lo |-> ##2 (res_sum == Q_MIN));

  p_upper_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_sum[OPW-1]) |-> (res_act >= 16'h8000));

  p_lower_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_sum[OPW-1]) |-> (res_act < 16'h8000));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_act) && $stable(res_sum)));
endmodule

bind neuron_mac_step nmac_chk u_nmac_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .res_valid(res_valid),
  .ev_sat_hi(ev_sat_hi), .ev_sat_lo(ev_sat_lo),
  .res_sum(res_sum), .res_act(res_act)
);

// File: tb/neuron_mac_step_test.sv
`timescale 1ns/1ps
module neuron_mac_step_test;
  localparam int N = 7;

  logic clk = 1'b0, rst_n = 1'b0, ld_en = 1'b0, ld_sel = 1'b0, start = 1'b0, first = 1'b0;
  logic [255:0] ld_line = '0;
  logic res_valid;
  logic [31:0] res_sum;
  logic [15:0] res_act;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  longint mw[N], mx[N];
  longint macc = 0;

  always #2 clk = ~clk;

  neuron_mac_step uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_line(ld_line),
    .start(start), .first(first), .res_valid(res_valid), .res_sum(res_sum), .res_act(res_act)
  );

  function automatic longint f_sat(longint v);
    if (v > 64'sd2147483647) return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic longint f_prod(longint a, longint b);
    longint p;
    p = a * b;
    if (p >= 0) return f_sat(p / 65536);
    return f_sat(-((-p + 65535) / 65536));   // floor toward minus infinity
  endfunction

  function automatic longint f_step(bit fst);
    longint s = 0;
    for (int i = 0; i < N; i++) s += f_prod(mw[i], mx[i]);
    if (!fst) s += macc;
    return f_sat(s);
  endfunction

  function automatic int f_idx(longint s);
    if (s < -524288) return 0;
    if (s > 524287) return 255;
    return int'((s + 524288) / 4096);
  endfunction

  function automatic int f_act(longint s);
    real x;
    x = (2.0 * real'(f_idx(s)) - 255.0) / 32.0;
    return $rtoi(65535.0 / (1.0 + $exp(-x)) + 0.5);
  endfunction

  function automatic longint f_rnd(longint r);
    return longint'($urandom_range(0, 32'(2*r))) - r;
  endfunction

  function automatic logic [255:0] f_pack(bit sel);
    logic [255:0] l;
    l = {$urandom(), 224'd0};
    for (int i = 0; i < N; i++) l[i*32 +: 32] = sel ? mx[i][31:0] : mw[i][31:0];
    return l;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_act(string req, longint act, longint exp);
    checks++;
    if (act > exp + 1 || act < exp - 1) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_both();
    @(negedge clk); ld_en = 1'b1; ld_sel = 1'b0; ld_line = f_pack(1'b0);
    @(negedge clk); ld_sel = 1'b1; ld_line = f_pack(1'b1);
    @(negedge clk); ld_en = 1'b0;
  endtask

  task automatic set_single(longint w, longint x);
    for (int i = 0; i < N; i++) begin mw[i] = 0; mx[i] = 0; end
    mw[3] = w; mx[3] = x;
    load_both();
  endtask

  task automatic run_step(bit fst, bit clobber, string rs, string ra);
    longint es, ea, hs, ha;
    @(negedge clk); start = 1'b1; first = fst;
    es = f_step(fst); macc = es; ea = f_act(es);
    @(negedge clk); start = 1'b0; first = 1'b0;
    if (clobber) begin   // R8: overwrite a slot right after the start edge
      for (int i = 0; i < N; i++) mw[i] = f_rnd(65536);
      ld_en = 1'b1; ld_sel = 1'b0; ld_line = f_pack(1'b0);
    end
    @(negedge clk); ld_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 early valid", longint'(res_valid), 0);
    @(negedge clk);
    chk("R5 valid", longint'(res_valid), 1);
    chk(rs, longint'($signed(res_sum)), es);
    chk_act(ra, longint'(res_act), ea);
    hs = longint'($signed(res_sum)); ha = longint'(res_act);
    repeat (2) @(negedge clk);
    chk("R9 hold sum", longint'($signed(res_sum)), hs);
    chk("R9 hold act", longint'(res_act), ha);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R5 watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint e[3];
    void'($urandom(32'd31337));
    repeat (4) @(negedge clk);
    chk("R10 valid", longint'(res_valid), 0);
    chk("R10 sum", longint'(res_sum), 0);
    chk("R10 act", longint'(res_act), 0);
    rst_n = 1'b1;

    // R10: slots and total start at zero
    for (int i = 0; i < N; i++) begin mw[i] = 0; mx[i] = 0; end
    macc = 0;
    run_step(1'b0, 1'b0, "R10 zero slots", "R7 zero total");

    // R2: floor of the shifted product, and per-lane saturation
    set_single(1, -1);
    run_step(1'b1, 1'b0, "R2 floor", "R7 minus one lsb");
    set_single(64'sh7FFF0000, 64'sh20000);
    run_step(1'b1, 1'b0, "R2 product sat", "R6 high clamp");

    // R6: clamp edges with a unit weight on one lane
    set_single(65536, -524288); run_step(1'b1, 1'b0, "R6 sum -8", "R6 index 0");
    set_single(65536, -524289); run_step(1'b1, 1'b0, "R6 sum below -8", "R6 low clamp");
    set_single(65536, 524287);  run_step(1'b1, 1'b0, "R6 sum under 8", "R6 index 255");
    set_single(65536, 524288);  run_step(1'b1, 1'b0, "R6 sum 8", "R6 high clamp");
    set_single(65536, 0);       run_step(1'b1, 1'b0, "R6 sum 0", "R6 index 128");

    // R3: chained accumulation 1.0 + 1.0 + 1.0
    set_single(65536, 65536);
    run_step(1'b1, 1'b0, "R3 fresh", "R7 one");
    run_step(1'b0, 1'b0, "R3 chained", "R7 two");
    run_step(1'b0, 1'b0, "R3 chained", "R7 three");

    // R4: saturation at both ends, held across steps
    for (int i = 0; i < N; i++) begin mw[i] = 64'sh7FFFFFFF; mx[i] = 64'sh7FFFFFFF; end
    load_both();
    run_step(1'b1, 1'b0, "R4 sat high", "R7 sat high");
    run_step(1'b0, 1'b0, "R4 sat high held", "R7 sat high held");
    for (int i = 0; i < N; i++) mx[i] = -64'sh80000000;
    load_both();
    run_step(1'b0, 1'b0, "R4 sat low", "R7 sat low");
    run_step(1'b0, 1'b0, "R4 sat low held", "R7 sat low held");

    // R5: back-to-back starts with feedback between them
    for (int i = 0; i < N; i++) begin mw[i] = f_rnd(65536); mx[i] = f_rnd(65536); end
    load_both();
    @(negedge clk); start = 1'b1; first = 1'b1; e[0] = f_step(1'b1); macc = e[0];
    @(negedge clk); first = 1'b0; e[1] = f_step(1'b0); macc = e[1];
    @(negedge clk); first = 1'b0; e[2] = f_step(1'b0); macc = e[2];
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 burst early", longint'(res_valid), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R5 burst valid", longint'(res_valid), 1);
      chk("R3 burst sum", longint'($signed(res_sum)), e[k]);
      chk_act("R7 burst act", longint'(res_act), f_act(e[k]));
    end
    @(negedge clk);
    chk("R5 burst end", longint'(res_valid), 0);

    // Random steps: R1 junk top word, R8 late loads
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < N; i++) begin mw[i] = f_rnd(65536); mx[i] = f_rnd(98304); end
      load_both();
      run_step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R1 R8 random sum", "R7 random act");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule